// File: doc/BRIEF.md
# Flash Byte Programming Controller

This block models the programming side of an on-chip flash code array. A host presents an address, a data byte and a mode code. A rising edge on the program strobe then starts a self-timed write of one byte, or a write of the protection bits. A rising edge on the erase command starts a chip erase. The array is held in flops, and its depth is a parameter so that simulation stays cheap. Every byte starts out erased at 0xFF. A byte write can only clear bits. Bits can be set back to one only by a full chip erase.

Progress is visible in two ways. The ready output is low for exactly the length of the timed operation. While a byte write is running, a code read of the address being written returns the new value with bit 7 inverted. Two protection bits are kept. The first blocks further byte programming. The second blocks code read-back. Both are sticky until a chip erase. Signature reads return fixed identification bytes, and one of them depends on the configured programming-voltage scheme. When the high-voltage scheme is configured, every timed operation also needs the high-voltage enable input.

Top module: `flashByteProg`

## Requirements
- R1: After reset, readyOut is 1, both protection bits are clear, and a code read (modeSel=2) of every address returns 0xFF.
- R2: A rising progStrobe while idle with modeSel=1 starts a byte write. readyOut drops at the first clock edge after the strobe is seen, stays 0 for exactly WRITE_CYCLES cycles, and the new byte can be read back once readyOut is 1 again.
- R3: A byte write stores (old byte AND dataIn), so a write can only clear bits. Writing 0x0F and then 0xF0 to a blank byte leaves 0x00.
- R4: While a byte write is busy, a code read of the address being written returns the value being stored with bit 7 inverted and bits 6..0 true. Reads of other addresses return their stored contents, and all bits are true after completion.
- R5: progStrobe and eraseCmd edges that arrive while readyOut is 0 are ignored: no second operation starts and the target byte is unchanged.
- R6: With hvMode=1, a strobe or erase command while vppHigh=0 is ignored (readyOut stays 1, contents unchanged). With hvMode=0, vppHigh has no effect.
- R7: A rising progStrobe with modeSel=4 runs a WRITE_CYCLES-long protection write. dataIn bit 0 sets the program lock and dataIn bit 1 sets the verify lock. Protection bits can only be set, never cleared, by this write.
- R8: While the program lock is set, byte-write strobes (modeSel=1) are ignored: readyOut stays 1 and no byte changes.
- R9: While the verify lock is set, code reads (modeSel=2) return 0x00.
- R10: Signature reads (modeSel=3) return 0x1E at address 0x30, 0x52 at 0x31, and at 0x32 either 0xFF (hvMode=1) or 0x05 (hvMode=0). Every other address returns 0x00. Signature reads are unaffected by the protection bits. Idle and write modes drive 0x00.
- R11: A rising eraseCmd while idle holds readyOut at 0 for exactly ERASE_CYCLES cycles. It then leaves every byte at 0xFF and clears both protection bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addrIn | input | ADDR_W | Byte or signature address |
| dataIn | input | 8 | Write data, or protection bits in mode 4 |
| modeSel | input | 3 | 0 idle, 1 byte write, 2 code read, 3 signature read, 4 protection write |
| progStrobe | input | 1 | Program strobe; a rising edge starts a write |
| eraseCmd | input | 1 | Chip erase command; a rising edge starts an erase |
| hvMode | input | 1 | Configuration: 1 selects the high-voltage programming scheme |
| vppHigh | input | 1 | High-voltage enable, needed for writes when hvMode=1 |
| dataOut | output | 8 | Read data, polling value or signature byte |
| readyOut | output | 1 | 1 when idle, 0 while a timed operation runs |

## Verification
The bench builds the block with ADDR_W=8, a 256-byte array. This lets the reset and erase checks sweep the whole array and lets the signature offsets 0x30 to 0x32 exist. WRITE_CYCLES=12 and ERASE_CYCLES=20 are short enough for about a hundred timed operations. They are still long enough that the polling read, the mid-write strobe and the first and last busy cycles fall on distinct edges. Random writes are confined to sixteen addresses, so most of them land on bytes that are no longer blank. This exercises the clear-only rule heavily.

// File: rtl/flashProgPkg.sv
package flashProgPkg;

  typedef enum logic [2:0] {
    MODE_IDLE  = 3'd0,
    MODE_WRITE = 3'd1,
    MODE_READ  = 3'd2,
    MODE_SIG   = 3'd3,
    MODE_LOCK  = 3'd4
  } modeE;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BYTE,
    ST_LOCK,
    ST_ERASE
  } stateE;

  // strobes from control to datapath
  typedef struct packed {
    logic captureByte;
    logic commitByte;
    logic captureLock;
    logic commitLock;
    logic commitErase;
    logic pollActive;
  } ctlStrobeT;

  localparam logic [7:0] SIG_MAKER   = 8'h1E;
  localparam logic [7:0] SIG_DEVICE  = 8'h52;
  localparam logic [7:0] SIG_VOLT_HV = 8'hFF;
  localparam logic [7:0] SIG_VOLT_LV = 8'h05;

endpackage

// File: rtl/flashProgCtrl.sv
module flashProgCtrl
  import flashProgPkg::*;
#(
  parameter int WRITE_CYCLES = 16,
  parameter int ERASE_CYCLES = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] modeSel,
  input  logic       progStrobe,
  input  logic       eraseCmd,
  input  logic       hvMode,
  input  logic       vppHigh,
  input  logic       lockProg,
  output ctlStrobeT  ctl,
  output logic       readyOut
);

  localparam int MAX_CYCLES = (WRITE_CYCLES > ERASE_CYCLES) ? WRITE_CYCLES : ERASE_CYCLES;
  localparam int CNT_W = $clog2(MAX_CYCLES + 1);
  localparam logic [CNT_W-1:0] WRITE_LOAD = CNT_W'(WRITE_CYCLES);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES);

  stateE            state;
  logic [CNT_W-1:0] cnt;
  logic             strobeQ;
  logic             eraseQ;
  modeE             mode;

  logic strobeRise, eraseRise, voltageOk, isIdle, lastCycle;
  logic startByte, startLock, startErase;

  assign mode       = modeE'(modeSel);
  assign strobeRise = progStrobe & ~strobeQ;
  assign eraseRise  = eraseCmd & ~eraseQ;
  assign voltageOk  = ~hvMode | vppHigh;
  assign isIdle     = (state == ST_IDLE);
  assign lastCycle  = !isIdle && (cnt == CNT_W'(1));

  // erase wins over a strobe seen on the same edge
  assign startErase = isIdle && eraseRise && voltageOk;
  assign startByte  = isIdle && !eraseRise && strobeRise && voltageOk &&
                      (mode == MODE_WRITE) && !lockProg;
  assign startLock  = isIdle && !eraseRise && strobeRise && voltageOk &&
                      (mode == MODE_LOCK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobeQ <= 1'b0;
      eraseQ  <= 1'b0;
    end else begin
      strobeQ <= progStrobe;
      eraseQ  <= eraseCmd;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (isIdle) begin
      if (startErase) begin
        state <= ST_ERASE;
        cnt   <= ERASE_LOAD;
      end else if (startByte) begin
        state <= ST_BYTE;
        cnt   <= WRITE_LOAD;
      end else if (startLock) begin
        state <= ST_LOCK;
        cnt   <= WRITE_LOAD;
      end
    end else if (lastCycle) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  always_comb begin
    ctl             = '0;
    ctl.captureByte = startByte;
    ctl.captureLock = startLock;
    ctl.commitByte  = lastCycle && (state == ST_BYTE);
    ctl.commitLock  = lastCycle && (state == ST_LOCK);
    ctl.commitErase = lastCycle && (state == ST_ERASE);
    ctl.pollActive  = (state == ST_BYTE);
  end

  assign readyOut = isIdle;

  AST_BUSY_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    !readyOut |-> (cnt != '0)) else $error("busy with empty counter"); // R2

  AST_READY_FALLS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.captureByte || ctl.captureLock) |=> !readyOut) else $error("ready did not fall"); // R2

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!isIdle && !lastCycle) |=> (state == $past(state))) else $error("busy operation disturbed"); // R5

  AST_NO_START_LOW_VOLT: assert property (@(posedge clk) disable iff (!rstN)
    (isIdle && hvMode && !vppHigh) |=> readyOut) else $error("started without high voltage"); // R6

endmodule

// File: rtl/flashProgData.sv
module flashProgData
  import flashProgPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobeT         ctl,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [7:0]        dataIn,
  input  logic [2:0]        modeSel,
  input  logic              hvMode,
  output logic [7:0]        dataOut,
  output logic              lockProg
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] SIG_OFF0 = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] SIG_OFF1 = ADDR_W'(8'h31);
  localparam logic [ADDR_W-1:0] SIG_OFF2 = ADDR_W'(8'h32);

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] lastAddr;
  logic [7:0]        lastData;
  logic [1:0]        pendLock;
  logic              lockVerify;
  modeE              mode;

  assign mode = modeE'(modeSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (ctl.commitErase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (ctl.commitByte) begin
      mem[lastAddr] <= lastData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastAddr <= '0;
      lastData <= 8'hFF;
      pendLock <= '0;
    end else begin
      if (ctl.captureByte) begin
        lastAddr <= addrIn;
        lastData <= mem[addrIn] & dataIn;
      end
      if (ctl.captureLock) pendLock <= dataIn[1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockProg   <= 1'b0;
      lockVerify <= 1'b0;
    end else if (ctl.commitErase) begin
      lockProg   <= 1'b0;
      lockVerify <= 1'b0;
    end else if (ctl.commitLock) begin
      lockProg   <= lockProg | pendLock[0];
      lockVerify <= lockVerify | pendLock[1];
    end
  end

  always_comb begin
    dataOut = 8'h00;
    case (mode)
      MODE_READ: begin
        if (lockVerify)                                 dataOut = 8'h00;
        else if (ctl.pollActive && addrIn == lastAddr)  dataOut = {~lastData[7], lastData[6:0]};
        else                                            dataOut = mem[addrIn];
      end
      MODE_SIG: begin
        if (addrIn == SIG_OFF0)      dataOut = SIG_MAKER;
        else if (addrIn == SIG_OFF1) dataOut = SIG_DEVICE;
        else if (addrIn == SIG_OFF2) dataOut = hvMode ? SIG_VOLT_HV : SIG_VOLT_LV;
      end
      default: dataOut = 8'h00;
    endcase
  end

  AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.commitByte, ctl.commitLock, ctl.commitErase})) else $error("two commits"); // R2

  AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commitByte |=> ((mem[$past(lastAddr)] & ~$past(mem[lastAddr])) == 8'h00))
    else $error("byte write set a bit"); // R3

  AST_LOCKED_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.captureByte |-> !lockProg) else $error("write accepted under lock"); // R8

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (lockProg && !ctl.commitErase) |=> lockProg) else $error("program lock dropped"); // R7

  AST_ERASE_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commitErase |=> (mem[0] == 8'hFF && mem[DEPTH-1] == 8'hFF && !lockProg && !lockVerify))
    else $error("erase incomplete"); // R11

endmodule

// File: rtl/flashByteProg.sv
module flashByteProg
  import flashProgPkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int WRITE_CYCLES = 16,
  parameter int ERASE_CYCLES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [7:0]        dataIn,
  input  logic [2:0]        modeSel,
  input  logic              progStrobe,
  input  logic              eraseCmd,
  input  logic              hvMode,
  input  logic              vppHigh,
  output logic [7:0]        dataOut,
  output logic              readyOut
);

  ctlStrobeT ctl;
  logic      lockProg;

  flashProgCtrl #(
    .WRITE_CYCLES(WRITE_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .modeSel   (modeSel),
    .progStrobe(progStrobe),
    .eraseCmd  (eraseCmd),
    .hvMode    (hvMode),
    .vppHigh   (vppHigh),
    .lockProg  (lockProg),
    .ctl       (ctl),
    .readyOut  (readyOut)
  );

  flashProgData #(
    .ADDR_W(ADDR_W)
  ) data_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .addrIn  (addrIn),
    .dataIn  (dataIn),
    .modeSel (modeSel),
    .hvMode  (hvMode),
    .dataOut (dataOut),
    .lockProg(lockProg)
  );

endmodule

// File: tb/flashByteProg_tb_top.sv
module flashByteProg_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW  = 8;
  localparam int WC  = 12;
  localparam int EC  = 20;
  localparam int NB  = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [7:0]    dataIn = '0;
  logic [2:0]    modeSel = 3'd0;
  logic          progStrobe = 1'b0;
  logic          eraseCmd = 1'b0;
  logic          hvMode = 1'b0;
  logic          vppHigh = 1'b0;
  logic [7:0]    dataOut;
  logic          readyOut;

  int checks = 0;
  int errors = 0;

  logic [7:0] expMem [NB];
  bit         expLockProg = 0;
  bit         expLockVerify = 0;

  flashByteProg #(.ADDR_W(AW), .WRITE_CYCLES(WC), .ERASE_CYCLES(EC)) dut_i (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .dataIn(dataIn), .modeSel(modeSel),
    .progStrobe(progStrobe), .eraseCmd(eraseCmd), .hvMode(hvMode), .vppHigh(vppHigh),
    .dataOut(dataOut), .readyOut(readyOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [7:0] a);
    return expLockVerify ? 8'h00 : expMem[a];
  endfunction

  function automatic logic [7:0] expSig(input logic [7:0] a);
    case (a)
      8'h30: return 8'h1E;
      8'h31: return 8'h52;
      8'h32: return hvMode ? 8'hFF : 8'h05;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit expAccept(input logic [2:0] m, input bit useErase);
    if (hvMode && !vppHigh) return 0;
    if (useErase) return 1;
    if (m == 3'd4) return 1;
    return (m == 3'd1) && !expLockProg;
  endfunction

  task automatic readCheck(input logic [7:0] a, input string req);
    modeSel = 3'd2; addrIn = a; #1;
    check(dataOut == expRead(a), req, "code read", dataOut, expRead(a));
  endtask

  // one timed operation: strobe (or erase), busy-length and polling checks, model update
  task automatic runOp(input logic [2:0] m, input logic [7:0] a, input logic [7:0] d,
                       input bit useErase, input string req);
    bit acc;
    logic [7:0] pv;
    int len;
    @(negedge clk);
    acc = expAccept(m, useErase);
    pv  = expMem[a] & d;
    len = useErase ? EC : WC;
    modeSel = m; addrIn = a; dataIn = d;
    if (useErase) eraseCmd = 1'b1; else progStrobe = 1'b1;
    @(negedge clk);
    progStrobe = 1'b0; eraseCmd = 1'b0;
    if (!acc) begin
      check(readyOut == 1'b1, req, "ignored op kept ready", readyOut, 1);
      modeSel = 3'd0;
      return;
    end
    check(readyOut == 1'b0, req, "ready low after start", readyOut, 0);
    if (m == 3'd1 && !useErase) begin
      modeSel = 3'd2; #1;
      check(dataOut == (expLockVerify ? 8'h00 : {~pv[7], pv[6:0]}), "R4", "poll value",
            dataOut, expLockVerify ? 8'h00 : {~pv[7], pv[6:0]});
      addrIn = a ^ 8'h01; #1;
      check(dataOut == expRead(a ^ 8'h01), "R4", "other address while busy", dataOut, expRead(a ^ 8'h01));
      addrIn = a; modeSel = m;
    end
    repeat (len - 1) @(negedge clk);
    check(readyOut == 1'b0, req, "ready low on last busy cycle", readyOut, 0);
    @(negedge clk);
    check(readyOut == 1'b1, req, "ready high after operation", readyOut, 1);
    if (useErase) begin
      for (int i = 0; i < NB; i++) expMem[i] = 8'hFF;
      expLockProg = 0; expLockVerify = 0;
    end else if (m == 3'd4) begin
      expLockProg   = expLockProg | d[0];
      expLockVerify = expLockVerify | d[1];
    end else begin
      expMem[a] = pv;
    end
    modeSel = 3'd0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int bad;
    int seedVal;
    seedVal = $urandom(32'd7319);
    for (int i = 0; i < NB; i++) expMem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(readyOut == 1'b1, "R1", "ready after reset", readyOut, 1);
    bad = 0;
    for (int i = 0; i < NB; i++) begin
      modeSel = 3'd2; addrIn = 8'(i); #1;
      if (dataOut != 8'hFF) bad++;
    end
    check(bad == 0, "R1", "blank bytes after reset", bad, 0);
    modeSel = 3'd0; #1;
    check(dataOut == 8'h00, "R10", "idle drives zero", dataOut, 0);

    // R2, R3 clear-only rewrite
    runOp(3'd1, 8'h80, 8'h0F, 0, "R2");
    readCheck(8'h80, "R2");
    runOp(3'd1, 8'h80, 8'hF0, 0, "R3");
    readCheck(8'h80, "R3");
    check(expMem[8'h80] == 8'h00, "R3", "model rewrite", expMem[8'h80], 0);

    // R10 signature in both schemes
    for (int k = 0; k < 2; k++) begin
      hvMode = k[0];
      for (int a = 8'h2F; a <= 8'h33; a++) begin
        modeSel = 3'd3; addrIn = 8'(a); #1;
        check(dataOut == expSig(8'(a)), "R10", "signature byte", dataOut, expSig(8'(a)));
      end
    end
    hvMode = 1'b0;

    // R5 strobe and erase during busy are ignored
    @(negedge clk);
    modeSel = 3'd1; addrIn = 8'h90; dataIn = 8'hAA; progStrobe = 1'b1;
    @(negedge clk); progStrobe = 1'b0;
    @(negedge clk);
    addrIn = 8'h91; dataIn = 8'h00; progStrobe = 1'b1; eraseCmd = 1'b1;
    @(negedge clk); progStrobe = 1'b0; eraseCmd = 1'b0;
    repeat (WC - 3) @(negedge clk);
    check(readyOut == 1'b0, "R5", "first write still busy", readyOut, 0);
    @(negedge clk);
    check(readyOut == 1'b1, "R5", "ready after first write only", readyOut, 1);
    expMem[8'h90] = 8'hAA;
    readCheck(8'h91, "R5");
    readCheck(8'h90, "R5");
    readCheck(8'h80, "R5");
    modeSel = 3'd0;

    // R6 voltage gating
    hvMode = 1'b1; vppHigh = 1'b0;
    runOp(3'd1, 8'hA0, 8'h00, 0, "R6");
    readCheck(8'hA0, "R6");
    runOp(3'd0, 8'h00, 8'h00, 1, "R6");
    readCheck(8'h80, "R6");
    vppHigh = 1'b1;
    runOp(3'd1, 8'hA0, 8'h3C, 0, "R6");
    readCheck(8'hA0, "R6");
    hvMode = 1'b0; vppHigh = 1'b0;
    runOp(3'd1, 8'hA1, 8'h5A, 0, "R6");
    readCheck(8'hA1, "R6");

    // random writes on a small address window
    for (int n = 0; n < 80; n++) begin
      logic [7:0] a, d;
      a = 8'($urandom % 16);
      d = 8'($urandom);
      hvMode  = ($urandom % 4) == 0;
      vppHigh = ($urandom % 3) != 0;
      runOp(3'd1, a, d, 0, "R3");
      readCheck(a, "R2");
    end
    hvMode = 1'b0; vppHigh = 1'b0;

    // R7, R9 verify lock
    runOp(3'd4, 8'h00, 8'h02, 0, "R7");
    readCheck(8'h80, "R9");
    check(dataOut == 8'h00, "R9", "verify lock hides data", dataOut, 0);
    modeSel = 3'd3; addrIn = 8'h31; #1;
    check(dataOut == 8'h52, "R10", "signature under lock", dataOut, 8'h52);
    runOp(3'd1, 8'hB0, 8'h11, 0, "R9");

    // R7, R8 program lock, verify lock stays set
    runOp(3'd4, 8'h00, 8'h01, 0, "R7");
    readCheck(8'hB0, "R7");
    runOp(3'd1, 8'hB1, 8'h00, 0, "R8");
    runOp(3'd4, 8'h00, 8'h00, 0, "R7");
    runOp(3'd1, 8'hB2, 8'h00, 0, "R8");
    check(expMem[8'hB2] == 8'hFF, "R8", "model untouched", expMem[8'hB2], 8'hFF);

    // R11 erase clears contents and locks
    runOp(3'd0, 8'h00, 8'h00, 1, "R11");
    bad = 0;
    for (int i = 0; i < NB; i++) begin
      modeSel = 3'd2; addrIn = 8'(i); #1;
      if (dataOut != 8'hFF) bad++;
    end
    check(bad == 0, "R11", "blank bytes after erase", bad, 0);
    runOp(3'd1, 8'hB1, 8'h42, 0, "R11");
    readCheck(8'hB1, "R11");
    check(dataOut == 8'h42, "R11", "write accepted after erase", dataOut, 8'h42);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule